// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block takes two double-precision operand words and a condition-flag word, decides how the first operand relates to the second, and returns the flag word rewritten to encode that relation. The relation is carried in three flag bits: zero, parity and carry. Each of the four outcomes (unordered, greater, less, equal) has its own pattern. The overflow, sign and auxiliary-carry bits are forced to zero. Every other bit of the incoming word is returned unchanged.

A caller presents both operands and the current flags together with a one-cycle valid strobe. One clock later the rewritten flag word appears on a registered output, and a done strobe is high for that cycle. The block raises no exceptions. It treats signalling and quiet NaNs the same way.

Top module: `fcmp_flag_gen`

## Requirements
- R1: If either operand is a NaN, the output has ZF=1, PF=1 and CF=1. A NaN is a word whose 11-bit exponent (bits 62:52) is all ones and whose 52-bit fraction (bits 51:0) is non-zero. Signalling and quiet NaNs are handled alike.
- R2: If neither operand is a NaN and the first is greater than the second, ZF, PF and CF are all 0.
- R3: If neither operand is a NaN and the first is less than the second, CF=1 and ZF=PF=0.
- R4: If the operands are equal in value, ZF=1 and PF=CF=0. +0 and -0 count as equal.
- R5: OF, SF and AF are 0 in every result word.
- R6: Flag positions are CF=bit 0, PF=bit 2, AF=bit 4, ZF=bit 6, SF=bit 7 and OF=bit 11. Every bit of the result outside these six equals the same bit of the incoming flag word.
- R7: Infinities take part in the ordering: -inf < every finite value < +inf. Denormals compare by their value.
- R8: When both operands are negative, the one with the larger magnitude is the smaller value.
- R9: done is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, flags_out holds its value. Reset clears flags_out and done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and flags are valid this cycle |
| op_a | input | 64 | First operand, IEEE-754 double |
| op_b | input | 64 | Second operand, IEEE-754 double |
| flags_in | input | 16 | Current condition-flag word |
| flags_out | output | 16 | Rewritten flag word, registered |
| done | output | 1 | Result valid strobe |

## Verification
The hardest cases to reach from the ports are the ones where a plain unsigned comparison of the raw words gives the wrong answer. These are the signed-zero pair, two negatives whose order is the reverse of their magnitudes, and a NaN whose exponent matches infinity. The bench sweeps every ordered pair drawn from a set of sixteen special encodings: both zeros, the smallest and largest denormals, ±1, ±2, 1.5, the largest finite value, both infinities, and quiet, signalling and negative NaNs. It derives the expected relation from native real arithmetic after its own bit-level NaN test. Each pair also carries a different background flag pattern, so the pass-through bits are exercised with both zeros and ones.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // Flag bit positions inside the condition word
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DW    = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [DW-1:0]    word,
  output logic             is_nan,
  output logic             is_zero,
  output logic             sign,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sign    = word[DW-1];
    expo    = word[MAG_W-1:FRAC_W];
    frac    = word[FRAC_W-1:0];
    mag     = word[MAG_W-1:0];
    is_nan  = (&expo) && (|frac);
    is_zero = ~(|mag);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             nan_a,
  input  logic             nan_b,
  input  logic             zero_a,
  input  logic             zero_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output rel_e             rel
);
  logic mag_lt, mag_eq;

  always_comb begin
    mag_lt = mag_a < mag_b;
    mag_eq = mag_a == mag_b;
    if (nan_a || nan_b)
      rel = REL_UN;
    else if (zero_a && zero_b)
      rel = REL_EQ;
    else if (sign_a != sign_b)
      rel = sign_a ? REL_LT : REL_GT;
    else if (mag_eq)
      rel = REL_EQ;
    else if (sign_a)
      // both negative: larger magnitude is the smaller value
      rel = mag_lt ? REL_GT : REL_LT;
    else
      rel = mag_lt ? REL_LT : REL_GT;
  end
endmodule

// File: rtl/fcmp_flag_merge.sv
module fcmp_flag_merge
  import fcmp_pkg::*;
#(
  parameter int FLAG_W = 16
) (
  input  rel_e              rel,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_nxt
);
  localparam logic [FLAG_W-1:0] CLR_MASK =
    FLAG_W'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
            (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));

  logic zf, pf, cf;

  always_comb begin
    zf = (rel == REL_EQ) || (rel == REL_UN);
    pf = (rel == REL_UN);
    cf = (rel == REL_LT) || (rel == REL_UN);
    flags_nxt = flags_in & ~CLR_MASK;
    flags_nxt[ZF_POS] = zf;
    flags_nxt[PF_POS] = pf;
    flags_nxt[CF_POS] = cf;
  end
endmodule

// File: rtl/fcmp_flag_gen.sv
module fcmp_flag_gen
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int FLAG_W = 16,
  localparam int DW    = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic              done
);
  localparam logic [FLAG_W-1:0] KEEP_MASK =
    ~FLAG_W'((1 << CF_POS) | (1 << PF_POS) | (1 << AF_POS) |
             (1 << ZF_POS) | (1 << SF_POS) | (1 << OF_POS));

  logic [1:0][DW-1:0] ops;
  logic [1:0]         nan_v, zero_v, sign_v;
  logic [MAG_W-1:0]   mag_v [2];
  rel_e               rel;
  logic [FLAG_W-1:0]  flags_nxt;

  assign ops = {op_b, op_a};

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word   (ops[g]),
      .is_nan (nan_v[g]),
      .is_zero(zero_v[g]),
      .sign   (sign_v[g]),
      .mag    (mag_v[g])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .nan_a (nan_v[0]),  .nan_b (nan_v[1]),
    .zero_a(zero_v[0]), .zero_b(zero_v[1]),
    .sign_a(sign_v[0]), .sign_b(sign_v[1]),
    .mag_a (mag_v[0]),  .mag_b (mag_v[1]),
    .rel   (rel)
  );

  fcmp_flag_merge #(.FLAG_W(FLAG_W)) u_mrg (
    .rel      (rel),
    .flags_in (flags_in),
    .flags_nxt(flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) flags_out <= flags_nxt;
    end
  end

  // R1: a NaN seen by the classifiers yields all three relation flags set
  assert_nan_sets_all_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (|nan_v)) |=> (flags_out[ZF_POS] && flags_out[PF_POS] && flags_out[CF_POS]));

  // R1..R4: only the four legal relation patterns can appear
  assert_legal_pattern_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($onehot0({flags_out[ZF_POS], flags_out[CF_POS]}) && !flags_out[PF_POS]) ||
             (flags_out[ZF_POS] && flags_out[PF_POS] && flags_out[CF_POS]));

  // R5: overflow, sign and aux-carry cleared in every result
  assert_cleared_bits_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !(flags_out[OF_POS] || flags_out[SF_POS] || flags_out[AF_POS]));

  // R6: untouched bits follow the incoming word
  assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((flags_out & KEEP_MASK) == ($past(flags_in) & KEEP_MASK)));

  // R9: done follows accepted valid by one cycle
  assert_done_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  assert_done_low_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(flags_out));
endmodule

// File: tb/sim_fcmp_flag_gen.sv
module sim_fcmp_flag_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [15:0] flags_in = '0;
  logic [15:0] flags_out;
  logic        done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  localparam logic [15:0] SIX = 16'h08D5; // bits 11,7,6,4,2,0

  always #2 clk = ~clk; // 250 MHz

  fcmp_flag_gen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
    .flags_out(flags_out), .done(done)
  );

  function automatic logic [63:0] val(input int k);
    case (k)
      0:  return 64'h0000_0000_0000_0000; // +0
      1:  return 64'h8000_0000_0000_0000; // -0
      2:  return 64'h0000_0000_0000_0001; // min denorm
      3:  return 64'h8000_0000_0000_0001; // -min denorm
      4:  return 64'h000F_FFFF_FFFF_FFFF; // max denorm
      5:  return 64'h3FF0_0000_0000_0000; // 1.0
      6:  return 64'hBFF0_0000_0000_0000; // -1.0
      7:  return 64'h4000_0000_0000_0000; // 2.0
      8:  return 64'hC000_0000_0000_0000; // -2.0
      9:  return 64'h7FEF_FFFF_FFFF_FFFF; // max finite
      10: return 64'h7FF0_0000_0000_0000; // +inf
      11: return 64'hFFF0_0000_0000_0000; // -inf
      12: return 64'h7FF8_0000_0000_0000; // quiet NaN
      13: return 64'h7FF0_0000_0000_0001; // signalling NaN
      14: return 64'hFFF8_0000_0000_0000; // negative NaN
      default: return 64'h3FF8_0000_0000_0000; // 1.5
    endcase
  endfunction

  function automatic bit is_nan(input logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
  endfunction

  function automatic bit special(input logic [63:0] w);
    return (w[62:52] == 11'h7FF) || (w[62:52] == 11'h000);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset flags", flags_out, 16'h0000);
    check("R9 reset done", {15'd0, done}, 16'h0001 ^ 16'h0001);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle done", {15'd0, done}, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [63:0] a, b;
        logic [15:0] fin, rel_bits;
        string tag;
        real ra, rb;
        a = val(i);
        b = val(j);
        fin = 16'hA5A5 ^ 16'(i * 16'h0F0F) ^ 16'(j * 16'h3333);
        op_a = a; op_b = b; flags_in = fin; in_valid = 1'b1;
        if (is_nan(a) || is_nan(b)) begin
          rel_bits = 16'h0045; tag = "R1";
        end else begin
          ra = $bitstoreal(a);
          rb = $bitstoreal(b);
          if (ra < rb) begin rel_bits = 16'h0001; tag = "R3"; end
          else if (ra == rb) begin rel_bits = 16'h0040; tag = "R4"; end
          else begin rel_bits = 16'h0000; tag = "R2"; end
          if (special(a) || special(b)) tag = {tag, "/R7"};
          if (a[63] && b[63]) tag = {tag, "/R8"};
        end
        @(negedge clk);
        check(tag, flags_out & 16'h0045, rel_bits);
        check("R5", flags_out & 16'h0890, 16'h0000);
        check("R6", flags_out & ~SIX, fin & ~SIX);
        check("R9 done", {15'd0, done}, 16'h0001);
      end
    end

    // R9: hold while idle; inputs change but output stays
    begin
      logic [15:0] last;
      last = flags_out;
      in_valid = 1'b0;
      op_a = val(12); op_b = val(5); flags_in = ~flags_in;
      @(negedge clk);
      check("R9 done low", {15'd0, done}, 16'h0000);
      @(negedge clk);
      check("R9 hold", flags_out, last);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule